// File: doc/BRIEF.md
# Radix-2 FFT Address Sequencer

This block produces the memory addresses for an in-place radix-2 FFT over `N` points, where `N` is a power of two and at least 4. After a start request it walks through `log2(N)` stages. Each stage holds `N/2` butterflies. For every butterfly it presents two operand addresses, the two matching write-back addresses and a twiddle-factor index. All of these appear in the same cycle, so a memory controller can read a pair and later write the results back to the same places.

The distance between the two operands is `N/2` in the first stage and halves in each stage after that. In the last stage that distance is 1, and the write-back addresses are the bit-reversed versions of the operand addresses, so the results land in natural frequency order. An advance strobe steps to the next butterfly, which lets the sequencer follow a datapath of any throughput. A one-cycle `done` pulse marks the end of the run.

Top module: `fft_addr_seq`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `busy`, `done` and `last_bfly` are 0.
- R2: A `start` sampled high while idle sets `busy` at the next clock edge. At that point the sequencer is at stage 0 and at butterfly 0.
- R3: While busy at stage index `s` (0-based), `rd_b = rd_a + S`, where the span `S = N >> (s+1)`.
- R4: Within a stage, `rd_a` takes, in ascending order, the addresses in `0..N-1` whose bit `log2(S)` is zero. Butterfly `j` of the stage uses the `j`-th such address.
- R5: The twiddle index `tw` is `(rd_a mod S) * (N / (2S))`.
- R6: In every stage but the last, `wr_a = rd_a` and `wr_b = rd_b`. In the last stage (`s = log2(N)-1`), `wr_a` and `wr_b` are `rd_a` and `rd_b` with their `log2(N)` address bits reversed.
- R7: Each `adv` sampled high while busy moves to the next butterfly at that clock edge. Without `adv`, every output holds its value.
- R8: The `stage` output advances by one after the `N/2`-th butterfly of a stage is advanced.
- R9: `last_bfly` is 1 exactly while busy on butterfly `N/2-1` of stage `log2(N)-1`.
- R10: An `adv` on the last butterfly clears `busy` and raises `done` for exactly one cycle at the same edge.
- R11: A `start` sampled while busy has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a sequence when idle |
| adv | input | 1 | Step to the next butterfly |
| busy | output | 1 | Sequence running; addresses valid |
| rd_a | output | log2(N) | Lower operand address |
| rd_b | output | log2(N) | Upper operand address |
| wr_a | output | log2(N) | Write-back address for the first result |
| wr_b | output | log2(N) | Write-back address for the second result |
| tw | output | log2(N) | Twiddle-factor index |
| stage | output | log2(N) | Current stage index, 0-based |
| last_bfly | output | 1 | Final butterfly of the final stage |
| done | output | 1 | One-cycle end-of-sequence pulse |

## Verification
All outputs come from state updated at a single clock edge. A `start` or `adv` sampled at one rising edge therefore shows its effect on `busy`, the addresses, `stage` and `done` one edge later, and `done` lasts for exactly that one cycle. The bench keeps a behavioural model that it updates at each rising edge from the same inputs the design sees. It compares every output at the following falling edge, so each result is checked in the cycle it falls due. Stalls and a `start` issued during a run are checked by comparing the outputs before and after the stimulus.

// File: rtl/fft_addr_seq.sv
module fft_addr_seq #(
  parameter int N = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 adv,
  output logic                 busy,
  output logic [$clog2(N)-1:0] rd_a,
  output logic [$clog2(N)-1:0] rd_b,
  output logic [$clog2(N)-1:0] wr_a,
  output logic [$clog2(N)-1:0] wr_b,
  output logic [$clog2(N)-1:0] tw,
  output logic [$clog2(N)-1:0] stage,
  output logic                 last_bfly,
  output logic                 done
);
  localparam int LG = $clog2(N);
  localparam logic [LG-1:0] HALF = LG'(N / 2);
  localparam logic [LG-1:0] LAST_STG = LG'(LG - 1);

  logic [LG-1:0] stg;
  logic [LG-2:0] j;
  logic [LG-1:0] jw, span, mask, k, kb;
  logic          fin_stg, last_j;

  assign jw      = {1'b0, j};
  assign span    = HALF >> stg;
  assign mask    = span - 1'b1;
  assign k       = ((jw & ~mask) << 1) | (jw & mask);
  assign kb      = k | span;
  assign fin_stg = (stg == LAST_STG);
  assign last_j  = &j;

  assign rd_a      = k;
  assign rd_b      = kb;
  assign tw        = (jw & mask) << stg;
  assign stage     = stg;
  assign last_bfly = busy && fin_stg && last_j;

  always_comb begin
    wr_a = k;
    wr_b = kb;
    if (fin_stg) begin
      for (int i = 0; i < LG; i++) begin
        wr_a[i] = k[LG-1-i];
        wr_b[i] = kb[LG-1-i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      done <= 1'b0;
      stg  <= '0;
      j    <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy <= 1'b1;
          stg  <= '0;
          j    <= '0;
        end
      end else if (adv) begin
        j <= j + 1'b1;
        if (last_j) begin
          if (fin_stg) begin
            busy <= 1'b0;
            done <= 1'b1;
          end else begin
            stg <= stg + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/fft_addr_seq_chk.sv
module fft_addr_seq_chk #(
  parameter int N = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 start,
  input logic                 adv,
  input logic                 busy,
  input logic [$clog2(N)-1:0] rd_a,
  input logic [$clog2(N)-1:0] rd_b,
  input logic [$clog2(N)-1:0] stage,
  input logic                 last_bfly,
  input logic                 done
);
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_after_last_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (last_bfly && adv) |=> (done && !busy));
  assert_last_in_run_R9: assert property (@(posedge clk) disable iff (!rst_n)
    last_bfly |-> busy);
  assert_pair_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (rd_b > rd_a));
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !adv) |=> ($stable(rd_a) && $stable(stage) && busy));
  assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> (busy && stage == '0 && rd_a == '0));
endmodule

bind fft_addr_seq fft_addr_seq_chk #(.N(N)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .adv(adv), .busy(busy),
  .rd_a(rd_a), .rd_b(rd_b), .stage(stage), .last_bfly(last_bfly), .done(done)
);

// File: tb/fft_addr_seq_tb_top.sv
module fft_addr_seq_tb_top;
  localparam int N  = 8;
  localparam int LG = $clog2(N);

  logic clk = 0, rst_n = 0, start = 0, adv = 0;
  logic busy, last_bfly, done;
  logic [LG-1:0] rd_a, rd_b, wr_a, wr_b, tw, stage;

  int errors = 0, checks = 0, cyc = 0;
  int m_busy = 0, m_stg = 0, m_j = 0, m_done = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  fft_addr_seq #(.N(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .adv(adv), .busy(busy),
    .rd_a(rd_a), .rd_b(rd_b), .wr_a(wr_a), .wr_b(wr_b), .tw(tw),
    .stage(stage), .last_bfly(last_bfly), .done(done)
  );

  function automatic int exp_k(int s, int jj);
    int sp = N >> (s + 1);
    int c = 0;
    for (int i = 0; i < N; i++) begin
      if ((i / sp) % 2 == 0) begin
        if (c == jj) return i;
        c++;
      end
    end
    return -1;
  endfunction

  function automatic int brev(int a);
    int r = 0;
    for (int i = 0; i < LG; i++) if ((a >> i) & 1) r |= 1 << (LG - 1 - i);
    return r;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_stg = 0; m_j = 0;
    end else begin
      cyc++;
      m_done = 0;
      if (!m_busy) begin
        if (start) begin m_busy = 1; m_stg = 0; m_j = 0; end
      end else if (adv) begin
        if (m_j == N/2 - 1) begin
          m_j = 0;
          if (m_stg == LG - 1) begin m_busy = 0; m_done = 1; end
          else m_stg++;
        end else m_j++;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      int k, sp, kb;
      chk(busy == m_busy, "R2", busy, m_busy);
      chk(done == m_done, "R10", done, m_done);
      chk(last_bfly == (m_busy && m_stg == LG-1 && m_j == N/2-1), "R9", last_bfly,
          m_busy && m_stg == LG-1 && m_j == N/2-1);
      if (m_busy) begin
        sp = N >> (m_stg + 1);
        k  = exp_k(m_stg, m_j);
        kb = k + sp;
        chk(stage == m_stg, "R8", stage, m_stg);
        chk(rd_a == k, "R4", rd_a, k);
        chk(rd_b == kb, "R3", rd_b, kb);
        chk(tw == (k % sp) * (N / (2 * sp)), "R5", tw, (k % sp) * (N / (2 * sp)));
        if (m_stg == LG - 1) begin
          chk(wr_a == brev(k) && wr_b == brev(kb), "R6", {wr_a, wr_b}, {brev(k), brev(kb)});
        end else begin
          chk(wr_a == k && wr_b == kb, "R6", {wr_a, wr_b}, {k, kb});
        end
      end
    end
  end

  task automatic run_to_end(int pat);
    int n = 0;
    while (busy && n < 1000) begin
      adv = (pat == 0) ? 1'b1 : ((n % 3) != 0);
      @(negedge clk);
      n++;
    end
    adv = 0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    logic [LG-1:0] sa, ss;
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0 && last_bfly == 0, "R1", {busy, done, last_bfly}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(busy == 0 && done == 0 && last_bfly == 0, "R1", {busy, done, last_bfly}, 0);

    start = 1; @(negedge clk); start = 0;
    adv = 1; repeat (2) @(negedge clk); adv = 0;
    sa = rd_a; ss = stage;
    repeat (3) @(negedge clk);
    chk(rd_a == sa && stage == ss && busy, "R7", rd_a, sa);
    start = 1; @(negedge clk); start = 0;
    @(negedge clk);
    chk(rd_a == sa && stage == ss && busy, "R11", rd_a, sa);
    adv = 1; repeat (3) @(negedge clk);
    start = 1; @(negedge clk); start = 0;
    run_to_end(1);

    start = 1; adv = 1; @(negedge clk); start = 0;
    run_to_end(0);
    chk(busy == 0, "R10", busy, 0);
    repeat (3) @(negedge clk);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule